// File: doc/BRIEF.md
# GPIO Register Decoder

This block is the register-access front end of an 8-bit general-purpose I/O controller. It sits on a simple memory-mapped bus that uses 12-bit byte offsets inside one 4 KB page. The block sorts every access into one of four groups: the masked data window, a small set of configuration registers, a read-only identification table at the top of the page, or an offset it does not accept.

A write to the data window changes only the bits chosen by the offset itself. Reads return data in the same cycle as the access. Any access that is not accepted leaves every register unchanged and raises a one-cycle error strobe. An accepted write raises a one-cycle update strobe, which later interrupt logic can use.

An elaboration parameter picks one of two register maps. The extended map adds an analog-mode register and moves the start of the reserved hole higher in the page. The register contents are driven out as ports, and so is the pad drive value, which is the data gated by the direction bits.

Top module: `gpio_regfront`

## Requirements
- R1: While reset is active, and in the cycles after it until the first access, every register output, `pad_out`, `err_pulse` and `upd_pulse` are 0. Reset is asserted asynchronously and takes effect internally only after two rising edges with `rst_n` high.
- R2: A read at an offset below 0x400 returns the data register ANDed with offset bits [9:2], in the same cycle, and raises no error.
- R3: A write at an offset below 0x400 sets data to (data & ~M) | (wdata & M), where M is offset bits [9:2]. It is followed by `upd_pulse` in the next cycle.
- R4: The configuration registers sit at these offsets: direction 0x400, sense 0x404, both-edges 0x408, event 0x40C, mask 0x410 and alternate function 0x420. A write stores `acc_wdata`, and a read returns the stored value in the same cycle.
- R5: When EXT=1, the analog-mode register at 0x528 is readable and writable. When EXT=0, offset 0x528 lies inside the reserved window, and `reg_amsel` stays 0.
- R6: A read from the reserved window returns 0 and is followed by `err_pulse`. The window runs from RSV to 0xFCC inclusive, where RSV is 0x424 when EXT=0 and 0x52C when EXT=1.
- R7: A read at offsets 0xFD0 to 0xFFF returns identification byte k = (offset - 0xFD0) >> 2, in the range 0 to 11. The byte is 0x30+k when EXT=0 and 0x60+k when EXT=1. The read raises no error.
- R8: A write at or above RSV, which includes the identification area, leaves every register unchanged. It is followed by `err_pulse` and no `upd_pulse`.
- R9: An offset between 0x400 and RSV that names no register reads 0 and is followed by `err_pulse`. A write there changes nothing and is also followed by `err_pulse`. Examples are 0x414 to 0x41C, and when EXT=1, 0x424 to 0x524.
- R10: `pad_out` equals data AND direction.
- R11: `err_pulse` and `upd_pulse` are high only in the cycle after an access with `acc_valid` high, and never both at once. A read that is accepted raises neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| acc_valid | input | 1 | An access is presented in this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_offset | input | 12 | Byte offset within the page |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, valid in the same cycle as a read |
| err_pulse | output | 1 | One-cycle strobe after a rejected access |
| upd_pulse | output | 1 | One-cycle strobe after an accepted write |
| reg_data | output | 8 | Data register |
| reg_dir | output | 8 | Direction register (1 = output) |
| reg_sense | output | 8 | Sense configuration |
| reg_both | output | 8 | Both-edges configuration |
| reg_event | output | 8 | Event configuration |
| reg_mask | output | 8 | Mask configuration |
| reg_altfn | output | 8 | Alternate-function configuration |
| reg_amsel | output | 8 | Analog-mode select (0 when EXT=0) |
| pad_out | output | 8 | Pad drive value: data gated by direction |

## Verification
The assertions take for granted that every offset, write flag and write datum is a known value whenever `acc_valid` is high. They also take for granted that the inputs do not change between clock edges, because read data and the strobes are judged on a single sampled access.

The stimulus meets these conditions. It changes the bus only on falling edges, and it presents one fully defined access per cycle. It lowers `acc_valid` between steps, so each strobe can be traced to exactly one access.

Both register maps run side by side on the same bus. Every word offset of the page is read, every word offset above the data window is written, and all 256 data masks are used for both writes and reads.

// File: rtl/gpio_regfront_pkg.sv
package gpio_regfront_pkg;
  localparam int AW   = 12;
  localparam int NCFG = 7;

  localparam int CFG_DIR   = 0;
  localparam int CFG_SENSE = 1;
  localparam int CFG_BOTH  = 2;
  localparam int CFG_EVENT = 3;
  localparam int CFG_MASK  = 4;
  localparam int CFG_ALTFN = 5;
  localparam int CFG_AMSEL = 6;

  localparam logic [AW-1:0] RSV_BASIC = 12'h424;
  localparam logic [AW-1:0] RSV_EXT   = 12'h52C;
  localparam logic [AW-1:0] RSV_TOP   = 12'hFCC;
  localparam logic [AW-1:0] ID_LO     = 12'hFD0;

  function automatic logic [AW-1:0] cfg_offset(int idx);
    case (idx)
      CFG_DIR:   return 12'h400;
      CFG_SENSE: return 12'h404;
      CFG_BOTH:  return 12'h408;
      CFG_EVENT: return 12'h40C;
      CFG_MASK:  return 12'h410;
      CFG_ALTFN: return 12'h420;
      CFG_AMSEL: return 12'h528;
      default:   return 12'h000;
    endcase
  endfunction

  // Identification byte k of the table, computed rather than stored.
  function automatic logic [7:0] id_value(bit ext, logic [3:0] k);
    return (ext ? 8'h60 : 8'h30) + {4'h0, k};
  endfunction
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_regfront_pkg::*;
#(
  parameter bit EXT = 1'b0,
  parameter int DW  = 8
) (
  input  logic [AW-1:0]   off,
  output logic            is_data,
  output logic [NCFG-1:0] cfg_hit,
  output logic            is_id,
  output logic            rd_ok,
  output logic            wr_ok
);
  localparam logic [AW-1:0] RSV_LO   = EXT ? RSV_EXT : RSV_BASIC;
  localparam logic [AW-1:0] DATA_LIM = AW'(1 << (DW + 2));

  logic in_rsv;
  logic any_cfg;

  for (genvar i = 0; i < NCFG; i++) begin : g_hit
    localparam bit LIVE = EXT || (i != CFG_AMSEL);
    assign cfg_hit[i] = LIVE && (off == cfg_offset(i));
  end

  always_comb begin
    is_data = off < DATA_LIM;
    in_rsv  = (off >= RSV_LO) && (off <= RSV_TOP);
    is_id   = off >= ID_LO;
    any_cfg = |cfg_hit;
    // Priority: data window, then reserved window, then ID table, then registers.
    rd_ok   = is_data || (!in_rsv && (is_id || any_cfg));
    wr_ok   = is_data || ((off < RSV_LO) && any_cfg);
  end
endmodule

// File: rtl/gpio_cfg_store.sv
module gpio_cfg_store
  import gpio_regfront_pkg::*;
#(
  parameter bit EXT = 1'b0,
  parameter int DW  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     data_we,
  input  logic [DW-1:0]            data_mask,
  input  logic [NCFG-1:0]          cfg_we,
  input  logic [DW-1:0]            wdata,
  output logic [DW-1:0]            data_q,
  output logic [NCFG-1:0][DW-1:0]  cfg_q
);
  logic [DW-1:0] data_d;

  always_comb data_d = (data_q & ~data_mask) | (wdata & data_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_we) data_q <= data_d;
  end

  for (genvar i = 0; i < NCFG; i++) begin : g_cfg
    if (i == CFG_AMSEL && !EXT) begin : g_absent
      assign cfg_q[i] = '0;
    end else begin : g_reg
      logic [DW-1:0] q;
      logic [DW-1:0] d;
      always_comb d = wdata;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         q <= '0;
        else if (cfg_we[i]) q <= d;
      end
      assign cfg_q[i] = q;
    end
  end
endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
  import gpio_regfront_pkg::*;
#(
  parameter bit EXT = 1'b0,
  parameter int DW  = 8
) (
  input  logic [AW-1:0]            off,
  input  logic                     is_data,
  input  logic [NCFG-1:0]          cfg_hit,
  input  logic                     is_id,
  input  logic                     rd_ok,
  input  logic [DW-1:0]            data_q,
  input  logic [NCFG-1:0][DW-1:0]  cfg_q,
  output logic [DW-1:0]            rdata
);
  logic [3:0] id_k;

  always_comb begin
    id_k  = off[5:2] - 4'h4;
    rdata = '0;
    if (!rd_ok) begin
      rdata = '0;
    end else if (is_data) begin
      rdata = data_q & off[DW+1:2];
    end else if (is_id) begin
      rdata = DW'(id_value(EXT, id_k));
    end else begin
      for (int i = 0; i < NCFG; i++) begin
        if (cfg_hit[i]) rdata = rdata | cfg_q[i];
      end
    end
  end
endmodule

// File: rtl/gpio_regfront.sv
module gpio_regfront
  import gpio_regfront_pkg::*;
#(
  parameter bit EXT = 1'b0,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic          acc_write,
  input  logic [AW-1:0] acc_offset,
  input  logic [DW-1:0] acc_wdata,
  output logic [DW-1:0] acc_rdata,
  output logic          err_pulse,
  output logic          upd_pulse,
  output logic [DW-1:0] reg_data,
  output logic [DW-1:0] reg_dir,
  output logic [DW-1:0] reg_sense,
  output logic [DW-1:0] reg_both,
  output logic [DW-1:0] reg_event,
  output logic [DW-1:0] reg_mask,
  output logic [DW-1:0] reg_altfn,
  output logic [DW-1:0] reg_amsel,
  output logic [DW-1:0] pad_out
);
  logic [1:0]                rs_q;
  logic                      rst_core_n;
  logic                      is_data, is_id, rd_ok, wr_ok;
  logic [NCFG-1:0]           cfg_hit;
  logic [NCFG-1:0]           cfg_we;
  logic                      data_we;
  logic [NCFG-1:0][DW-1:0]   cfg_q;
  logic [DW-1:0]             data_q;
  logic [DW-1:0]             mux_rdata;
  logic                      err_d, upd_d;

  // Reset: asserted asynchronously, released after two clean edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  gpio_addr_decode #(.EXT(EXT), .DW(DW)) dec_i (
    .off     (acc_offset),
    .is_data (is_data),
    .cfg_hit (cfg_hit),
    .is_id   (is_id),
    .rd_ok   (rd_ok),
    .wr_ok   (wr_ok)
  );

  always_comb begin
    data_we = acc_valid && acc_write && is_data;
    cfg_we  = (acc_valid && acc_write && wr_ok) ? cfg_hit : '0;
    err_d   = acc_valid && (acc_write ? !wr_ok : !rd_ok);
    upd_d   = acc_valid && acc_write && wr_ok;
  end

  gpio_cfg_store #(.EXT(EXT), .DW(DW)) store_i (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .data_we   (data_we),
    .data_mask (acc_offset[DW+1:2]),
    .cfg_we    (cfg_we),
    .wdata     (acc_wdata),
    .data_q    (data_q),
    .cfg_q     (cfg_q)
  );

  gpio_rd_mux #(.EXT(EXT), .DW(DW)) mux_i (
    .off     (acc_offset),
    .is_data (is_data),
    .cfg_hit (cfg_hit),
    .is_id   (is_id),
    .rd_ok   (rd_ok),
    .data_q  (data_q),
    .cfg_q   (cfg_q),
    .rdata   (mux_rdata)
  );

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      err_pulse <= 1'b0;
      upd_pulse <= 1'b0;
    end else begin
      err_pulse <= err_d;
      upd_pulse <= upd_d;
    end
  end

  assign acc_rdata = (acc_valid && !acc_write) ? mux_rdata : '0;
  assign reg_data  = data_q;
  assign reg_dir   = cfg_q[CFG_DIR];
  assign reg_sense = cfg_q[CFG_SENSE];
  assign reg_both  = cfg_q[CFG_BOTH];
  assign reg_event = cfg_q[CFG_EVENT];
  assign reg_mask  = cfg_q[CFG_MASK];
  assign reg_altfn = cfg_q[CFG_ALTFN];
  assign reg_amsel = cfg_q[CFG_AMSEL];
  assign pad_out   = data_q & cfg_q[CFG_DIR];
endmodule

// File: rtl/gpio_regfront_chk.sv
module gpio_regfront_chk
  import gpio_regfront_pkg::*;
#(
  parameter bit EXT = 1'b0,
  parameter int DW  = 8
) (
  input logic            clk,
  input logic            rst_core_n,
  input logic            acc_valid,
  input logic            acc_write,
  input logic [AW-1:0]   acc_offset,
  input logic [DW-1:0]   acc_wdata,
  input logic [DW-1:0]   acc_rdata,
  input logic            err_pulse,
  input logic            upd_pulse,
  input logic [DW-1:0]   reg_data,
  input logic [8*DW-1:0] regs_all
);
  localparam logic [AW-1:0] RSV_LO   = EXT ? RSV_EXT : RSV_BASIC;
  localparam logic [AW-1:0] DATA_LIM = AW'(1 << (DW + 2));

  assert_excl_pulses_R11: assert property (@(posedge clk) disable iff (!rst_core_n)
    !(err_pulse && upd_pulse));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_core_n)
    !acc_valid |=> (!err_pulse && !upd_pulse));

  assert_wr_reject_R8: assert property (@(posedge clk) disable iff (!rst_core_n)
    (acc_valid && acc_write && acc_offset >= RSV_LO)
    |=> (err_pulse && !upd_pulse && $stable(regs_all)));

  assert_rsv_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (acc_valid && !acc_write && acc_offset >= RSV_LO && acc_offset <= RSV_TOP)
    |-> (acc_rdata == '0));

  assert_rsv_read_err_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (acc_valid && !acc_write && acc_offset >= RSV_LO && acc_offset <= RSV_TOP)
    |=> err_pulse);

  assert_data_write_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    (acc_valid && acc_write && acc_offset < DATA_LIM)
    |=> (upd_pulse && reg_data == (($past(reg_data) & ~$past(acc_offset[DW+1:2]))
                                 | ($past(acc_wdata) & $past(acc_offset[DW+1:2])))));

  assert_data_read_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    (acc_valid && !acc_write && acc_offset < DATA_LIM)
    |-> (acc_rdata == (reg_data & acc_offset[DW+1:2])));

  assert_id_read_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
    (acc_valid && !acc_write && acc_offset >= ID_LO)
    |-> (acc_rdata == DW'(id_value(EXT, acc_offset[5:2] - 4'h4))));
endmodule

bind gpio_regfront gpio_regfront_chk #(.EXT(EXT), .DW(DW)) chk_i (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .acc_valid  (acc_valid),
  .acc_write  (acc_write),
  .acc_offset (acc_offset),
  .acc_wdata  (acc_wdata),
  .acc_rdata  (acc_rdata),
  .err_pulse  (err_pulse),
  .upd_pulse  (upd_pulse),
  .reg_data   (reg_data),
  .regs_all   ({reg_data, reg_dir, reg_sense, reg_both, reg_event,
                reg_mask, reg_altfn, reg_amsel})
);

// File: tb/gpio_regfront_tb.sv
module gpio_regfront_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid, acc_write;
  logic [11:0] acc_offset;
  logic [7:0]  acc_wdata;

  logic [7:0]  rd_b, rd_x, po_b, po_x;
  logic        err_b, err_x, upd_b, upd_x;
  logic [7:0]  rg_b [8];
  logic [7:0]  rg_x [8];

  // Model: slot 0 data, 1 dir, 2 sense, 3 both, 4 event, 5 mask, 6 altfn, 7 amsel
  logic [7:0]  m [2][8];
  int          n_chk  = 0;
  int          n_fail = 0;

  always #4 clk = ~clk;

  gpio_regfront #(.EXT(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_offset(acc_offset), .acc_wdata(acc_wdata), .acc_rdata(rd_b),
    .err_pulse(err_b), .upd_pulse(upd_b), .reg_data(rg_b[0]), .reg_dir(rg_b[1]),
    .reg_sense(rg_b[2]), .reg_both(rg_b[3]), .reg_event(rg_b[4]), .reg_mask(rg_b[5]),
    .reg_altfn(rg_b[6]), .reg_amsel(rg_b[7]), .pad_out(po_b));

  gpio_regfront #(.EXT(1'b1)) dut_x (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_offset(acc_offset), .acc_wdata(acc_wdata), .acc_rdata(rd_x),
    .err_pulse(err_x), .upd_pulse(upd_x), .reg_data(rg_x[0]), .reg_dir(rg_x[1]),
    .reg_sense(rg_x[2]), .reg_both(rg_x[3]), .reg_event(rg_x[4]), .reg_mask(rg_x[5]),
    .reg_altfn(rg_x[6]), .reg_amsel(rg_x[7]), .pad_out(po_x));

  function automatic int rsv(int v);
    return (v != 0) ? 'h52C : 'h424;
  endfunction

  function automatic int cfg_slot(int v, int off);
    case (off)
      'h400: return 1;
      'h404: return 2;
      'h408: return 3;
      'h40C: return 4;
      'h410: return 5;
      'h420: return 6;
      'h528: return (v != 0) ? 7 : -1;
      default: return -1;
    endcase
  endfunction

  function automatic bit in_rsv(int v, int off);
    return off >= rsv(v) && off <= 'hFCC;
  endfunction

  function automatic bit rd_ok_m(int v, int off);
    if (off < 'h400) return 1'b1;
    if (in_rsv(v, off)) return 1'b0;
    return off >= 'hFD0 || cfg_slot(v, off) >= 0;
  endfunction

  function automatic bit wr_ok_m(int v, int off);
    return off < 'h400 || (off < rsv(v) && cfg_slot(v, off) >= 0);
  endfunction

  function automatic logic [7:0] rd_m(int v, int off);
    int s = cfg_slot(v, off);
    if (off < 'h400) return m[v][0] & 8'(off >> 2);
    if (in_rsv(v, off)) return 8'h00;
    if (off >= 'hFD0) return 8'(((v != 0) ? 'h60 : 'h30) + ((off - 'hFD0) >> 2));
    if (s >= 0) return m[v][s];
    return 8'h00;
  endfunction

  function automatic string region(int off);
    if (off < 'h400) return "R2";
    if (off >= 'hFD0) return "R7";
    if (off == 'h528) return "R5";
    if (cfg_slot(0, off) >= 0) return "R4";
    if (off >= 'h424 && off <= 'hFCC) return "R6";
    return "R9";
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_regs(string req);
    for (int k = 0; k < 8; k++) begin
      chk(req, int'(rg_b[k]), int'(m[0][k]));
      chk(req, int'(rg_x[k]), int'(m[1][k]));
    end
    chk("R10", int'(po_b), int'(m[0][0] & m[0][1]));
    chk("R10", int'(po_x), int'(m[1][0] & m[1][1]));
  endtask

  task automatic access(bit wr, int off, logic [7:0] wd, string req);
    @(negedge clk);
    acc_valid  = 1'b1;
    acc_write  = wr;
    acc_offset = 12'(off);
    acc_wdata  = wd;
    #1;
    if (!wr) begin
      chk(req, int'(rd_b), int'(rd_m(0, off)));
      chk(req, int'(rd_x), int'(rd_m(1, off)));
    end
    @(posedge clk);
    #1;
    acc_valid = 1'b0;
    for (int v = 0; v < 2; v++) begin
      if (wr && wr_ok_m(v, off)) begin
        if (off < 'h400) m[v][0] = (m[v][0] & ~8'(off >> 2)) | (wd & 8'(off >> 2));
        else             m[v][cfg_slot(v, off)] = wd;
      end
    end
    chk({req, "/R11 err"}, int'(err_b), wr ? int'(!wr_ok_m(0, off)) : int'(!rd_ok_m(0, off)));
    chk({req, "/R11 err"}, int'(err_x), wr ? int'(!wr_ok_m(1, off)) : int'(!rd_ok_m(1, off)));
    chk({req, "/R11 upd"}, int'(upd_b), int'(wr && wr_ok_m(0, off)));
    chk({req, "/R11 upd"}, int'(upd_x), int'(wr && wr_ok_m(1, off)));
    check_regs(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int cfg_offs [7] = '{'h400, 'h404, 'h408, 'h40C, 'h410, 'h420, 'h528};
    for (int v = 0; v < 2; v++)
      for (int k = 0; k < 8; k++) m[v][k] = 8'h00;
    rst_n = 1'b0; acc_valid = 1'b0; acc_write = 1'b0;
    acc_offset = '0; acc_wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 err", int'(err_b | err_x), 0);
    chk("R1 upd", int'(upd_b | upd_x), 0);
    check_regs("R1");

    // R4, R5: configuration registers, write then read back
    foreach (cfg_offs[i])
      access(1'b1, cfg_offs[i], 8'(8'hA0 + 8'(i * 13)), (cfg_offs[i] == 'h528) ? "R5" : "R4");
    foreach (cfg_offs[i])
      access(1'b0, cfg_offs[i], 8'h00, (cfg_offs[i] == 'h528) ? "R5" : "R4");

    // R10: mixed direction for the pad gating
    access(1'b1, 'h400, 8'hC3, "R10");

    // R3: every data mask with a varying pattern
    for (int msk = 0; msk < 256; msk++)
      access(1'b1, msk << 2, 8'((msk * 37) ^ 8'h5A), "R3");
    // R2: every data mask read back
    for (int msk = 0; msk < 256; msk++)
      access(1'b0, (msk << 2) | (msk & 3), 8'h00, "R2");

    // R6, R7, R9, R4, R5: read sweep over every word above the data window
    for (int off = 'h400; off < 'h1000; off += 4)
      access(1'b0, off, 8'h00, region(off));

    // R7: identification table at unaligned offsets
    for (int off = 'hFD0; off < 'h1000; off++)
      access(1'b0, off, 8'h00, "R7");

    // R8, R9: write sweep above the data window
    for (int off = 'h404; off < 'h1000; off += 4)
      access(1'b1, off, 8'(off >> 2), "R8/R9");

    // Final readback after the write sweep
    foreach (cfg_offs[i])
      access(1'b0, cfg_offs[i], 8'h00, (cfg_offs[i] == 'h528) ? "R5" : "R4");

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule